// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit carries out the set-vector-length operation of a vector-capable core. It takes the already decoded fields of one such operation, together with the current 64-bit vector state word, and works out a new maximum vector length and a new vector length. It also produces an optional write to a destination register and an optional 4-bit condition field. The state word itself, the register file and the condition register live outside the unit. The unit reads them through its inputs and returns the new values with write-enables.

The new length comes from one of four places. It can keep the stored length, or take the 7-bit immediate plus one, a source register value, or the loop counter. The choice depends on the set-length flag and on whether the raw source and destination field numbers are zero. A register or counter value that does not fit in 7 bits saturates to 127. The chosen length is then limited to the maximum length. Either limit raises the summary-overflow bit of the condition field. When the maximum length is set, the same operation also loads the vertical-first bit and clears the persistence bit. Every result is registered: an execute strobe in one cycle gives valid outputs, with their write-enables, in the next cycle.

The state word uses these LSB-0 bit positions. Maximum length is [63:57] and length is [56:50]; these are bits 0:6 and 7:13 when numbered from the most significant bit. Bit [1] is persistence and bit [0] is vertical-first.

Top module: `vl_set_unit`

## Requirements
- R1: The effective immediate is imm_i + 1 taken modulo 128. When set_max_i is 1, the new maximum length (state_o[63:57]) is that value, so imm_i = 127 gives 0.
- R2: When set_max_i is 0, the maximum length is kept from state_i[63:57].
- R3: When set_len_i is 0, the candidate length is the stored length state_i[56:50].
- R4: When set_len_i is 1 and src_field_i is nonzero, the candidate length is src_val_i. Any unsigned value above 127 becomes 127 and sets overflow.
- R5: When set_len_i is 1 and both src_field_i and dst_field_i are zero, the candidate length is the effective immediate.
- R6: When set_len_i is 1, src_field_i is zero and dst_field_i is nonzero, the candidate length is ctr_i. Any unsigned value above 127 becomes 127 and sets overflow.
- R7: A candidate length greater than the maximum length is replaced by the maximum length and sets overflow. The final length is written to state_o[56:50].
- R8: When dst_field_i is nonzero, rt_we_o is raised with rt_idx_o equal to dst_field_i and rt_data_o equal to the final length zero-extended to 64 bits. Otherwise rt_we_o stays low.
- R9: When set_max_i is 1, state_o[0] takes vfirst_i and state_o[1] is cleared. When set_max_i is 0, both bits keep their value from state_i.
- R10: When rec_i is 1, cr_we_o is raised even if dst_field_i is zero. cr_o is {0, length nonzero, length zero, overflow} in the order [3]..[0]. When rec_i is 0, cr_we_o stays low.
- R11: State bits [49:2] pass through unchanged. All outputs are registered: they are valid, with their write-enables, in the cycle after exec_i. Without exec_i, and during reset, every write-enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | Execute strobe for one operation |
| imm_i | input | 7 | Immediate length field, encodes value minus one |
| set_max_i | input | 1 | Load maximum length from the immediate |
| set_len_i | input | 1 | Load a new length |
| vfirst_i | input | 1 | Vertical-first value, applied with set_max_i |
| src_field_i | input | 5 | Raw source register field number |
| dst_field_i | input | 5 | Raw destination register field number |
| src_val_i | input | 64 | Value of the source register |
| ctr_i | input | 64 | Loop counter value |
| rec_i | input | 1 | Record bit: produce the condition field |
| state_i | input | 64 | Current vector state word |
| state_o | output | 64 | Updated vector state word |
| state_we_o | output | 1 | Write-enable for the state word |
| rt_we_o | output | 1 | Write-enable for the destination register |
| rt_idx_o | output | 5 | Destination register number |
| rt_data_o | output | 64 | Destination register value |
| cr_we_o | output | 1 | Write-enable for the condition field |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The assertions expect exec_i to be held low for as long as rst_n is low. They also expect state_i, src_val_i and ctr_i to be known values in every cycle that exec_i is high. The registered-output checks in particular depend on the state word staying stable from the strobe until the capture edge. The bench keeps to these conditions in three ways. It holds the strobe low through reset and drives every operand from its own model at the falling edge. It feeds the state input from a model copy of the state word, which changes only at falling edges. Its random operands cover values on both sides of 127 and every combination of zero and nonzero field numbers.

// File: rtl/vlset_pkg.sv
// Package: shared types and index helpers for the vector length setting unit.
// Assumes LSB-0 indexing of the state word throughout the design.
package vlset_pkg;

    // Source of the candidate vector length.
    typedef enum logic [1:0] {
        VL_FROM_STATE = 2'd0,
        VL_FROM_REG   = 2'd1,
        VL_FROM_IMM   = 2'd2,
        VL_FROM_CTR   = 2'd3
    } vl_src_e;

    // Bit positions inside the 4-bit condition field.
    localparam int unsigned CR_LT = 3;
    localparam int unsigned CR_GT = 2;
    localparam int unsigned CR_EQ = 1;
    localparam int unsigned CR_SO = 0;

    // Low bit of the maximum-length field for a state word of given widths.
    function automatic int unsigned mvl_lsb(input int unsigned state_w, input int unsigned len_w);
        return state_w - len_w;
    endfunction

    // Low bit of the length field, directly under the maximum-length field.
    function automatic int unsigned vl_lsb(input int unsigned state_w, input int unsigned len_w);
        return state_w - 2 * len_w;
    endfunction

endpackage

// File: rtl/vl_src_select.sv
// Module: vl_src_select
// Picks the candidate vector length from the stored length, the immediate
// plus one, a source register or the loop counter. Register and counter
// values wider than LEN_W saturate to all ones and flag overflow.
// Assumes the raw field numbers are presented undecoded (zero means "none").
module vl_src_select
    import vlset_pkg::*;
#(
    parameter int unsigned LEN_W   = 7,
    parameter int unsigned FIELD_W = 5,
    parameter int unsigned DATA_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_valid_i,
    input  logic [LEN_W-1:0]   imm_i,
    input  logic               set_len_i,
    input  logic [FIELD_W-1:0] src_field_i,
    input  logic [FIELD_W-1:0] dst_field_i,
    input  logic [DATA_W-1:0]  src_val_i,
    input  logic [DATA_W-1:0]  ctr_i,
    input  logic [LEN_W-1:0]   kept_len_i,
    output logic [LEN_W-1:0]   eff_imm_o,
    output logic [LEN_W-1:0]   cand_o,
    output logic               sat_ovf_o
);

    localparam logic [LEN_W-1:0]  LEN_ALL   = '1;
    localparam logic [DATA_W-1:0] LEN_LIMIT = {{(DATA_W-LEN_W){1'b0}}, LEN_ALL};

    vl_src_e             kind;
    logic [LEN_W:0]      imm_sum;
    logic [LEN_W-1:0]    reg_len;
    logic                reg_ovf;
    logic [LEN_W-1:0]    ctr_len;
    logic                ctr_ovf;

    // Saturate a full-width value into LEN_W bits.
    function automatic logic [LEN_W:0] saturate(input logic [DATA_W-1:0] v);
        if (v > LEN_LIMIT) begin
            return {1'b1, LEN_ALL};
        end
        return {1'b0, v[LEN_W-1:0]};
    endfunction

    // Effective immediate: stored field plus one, wrapping in LEN_W bits.
    always_comb begin
        imm_sum   = {1'b0, imm_i} + {{LEN_W{1'b0}}, 1'b1};
        eff_imm_o = imm_sum[LEN_W-1:0];
    end

    // Saturated register and counter candidates.
    always_comb begin
        {reg_ovf, reg_len} = saturate(src_val_i);
        {ctr_ovf, ctr_len} = saturate(ctr_i);
    end

    // Choose the source from the set-length flag and the field numbers.
    always_comb begin
        if (!set_len_i) begin
            kind = VL_FROM_STATE;
        end else if (src_field_i != '0) begin
            kind = VL_FROM_REG;
        end else if (dst_field_i == '0) begin
            kind = VL_FROM_IMM;
        end else begin
            kind = VL_FROM_CTR;
        end
    end

    // Multiplex the candidate and its saturation flag.
    always_comb begin
        unique case (kind)
            VL_FROM_REG: begin
                cand_o    = reg_len;
                sat_ovf_o = reg_ovf;
            end
            VL_FROM_IMM: begin
                cand_o    = eff_imm_o;
                sat_ovf_o = 1'b0;
            end
            VL_FROM_CTR: begin
                cand_o    = ctr_len;
                sat_ovf_o = ctr_ovf;
            end
            default: begin
                cand_o    = kept_len_i;
                sat_ovf_o = 1'b0;
            end
        endcase
    end

    // R4 / R6: a saturated source always yields the all-ones length.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid_i && sat_ovf_o) |-> (cand_o == LEN_ALL));

    // R3: with set-length low the stored length is used and no overflow comes from the source.
    assert_keep_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid_i && !set_len_i) |-> (cand_o == kept_len_i && !sat_ovf_o));

endmodule

// File: rtl/vl_len_clamp.sv
// Module: vl_len_clamp
// Limits the candidate length to the maximum length and merges the
// clamp overflow with any saturation overflow from source selection.
// Assumes both lengths are unsigned and of equal width.
module vl_len_clamp #(
    parameter int unsigned LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid_i,
    input  logic [LEN_W-1:0] cand_i,
    input  logic [LEN_W-1:0] max_i,
    input  logic             in_ovf_i,
    output logic [LEN_W-1:0] len_o,
    output logic             ovf_o
);

    logic too_long;

    // Compare and clamp in one step.
    always_comb begin
        too_long = (cand_i > max_i);
        len_o    = too_long ? max_i : cand_i;
        ovf_o    = in_ovf_i | too_long;
    end

    // R7: the final length never exceeds the maximum.
    assert_len_within_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid_i |-> (len_o <= max_i));

    // R7: overflow without source saturation only when the candidate was cut.
    assert_clamp_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid_i && ovf_o && !in_ovf_i) |-> (len_o == max_i && len_o != cand_i));

endmodule

// File: rtl/vl_state_merge.sv
// Module: vl_state_merge
// Builds the updated state word: new maximum length and length fields at
// the top, mode bits at the bottom, every other bit copied through.
// Assumes persistence at bit 1 and vertical-first at bit 0 (LSB-0).
module vl_state_merge
    import vlset_pkg::*;
#(
    parameter int unsigned STATE_W = 64,
    parameter int unsigned LEN_W   = 7
) (
    input  logic [STATE_W-1:0] state_i,
    input  logic [LEN_W-1:0]   max_len_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               set_max_i,
    input  logic               vfirst_i,
    output logic [STATE_W-1:0] state_o
);

    localparam int unsigned MVL_LO  = mvl_lsb(STATE_W, LEN_W);
    localparam int unsigned VL_LO   = vl_lsb(STATE_W, LEN_W);
    localparam int unsigned PST_BIT = 1;
    localparam int unsigned VF_BIT  = 0;

    // Overwrite the length fields and, on a maximum-length load, the mode bits.
    always_comb begin
        state_o                       = state_i;
        state_o[MVL_LO +: LEN_W]      = max_len_i;
        state_o[VL_LO +: LEN_W]       = len_i;
        if (set_max_i) begin
            state_o[VF_BIT]  = vfirst_i;
            state_o[PST_BIT] = 1'b0;
        end
    end

endmodule

// File: rtl/vl_set_unit.sv
// Module: vl_set_unit
// Executes one set-vector-length operation per execute strobe. It computes
// the maximum length and the length, saturates and clamps with overflow,
// and registers the new state word, the destination register write and
// the condition field, each with its own write-enable.
// Assumes the caller holds the state word externally and feeds it back on
// state_i, and keeps exec_i low during reset.
module vl_set_unit
    import vlset_pkg::*;
#(
    parameter int unsigned STATE_W = 64,
    parameter int unsigned LEN_W   = 7,
    parameter int unsigned FIELD_W = 5,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned CR_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exec_i,
    input  logic [LEN_W-1:0]   imm_i,
    input  logic               set_max_i,
    input  logic               set_len_i,
    input  logic               vfirst_i,
    input  logic [FIELD_W-1:0] src_field_i,
    input  logic [FIELD_W-1:0] dst_field_i,
    input  logic [DATA_W-1:0]  src_val_i,
    input  logic [DATA_W-1:0]  ctr_i,
    input  logic               rec_i,
    input  logic [STATE_W-1:0] state_i,
    output logic [STATE_W-1:0] state_o,
    output logic               state_we_o,
    output logic               rt_we_o,
    output logic [FIELD_W-1:0] rt_idx_o,
    output logic [DATA_W-1:0]  rt_data_o,
    output logic               cr_we_o,
    output logic [CR_W-1:0]    cr_o
);

    localparam int unsigned MVL_LO = mvl_lsb(STATE_W, LEN_W);
    localparam int unsigned VL_LO  = vl_lsb(STATE_W, LEN_W);

    logic [LEN_W-1:0]   kept_max;
    logic [LEN_W-1:0]   kept_len;
    logic [LEN_W-1:0]   eff_imm;
    logic [LEN_W-1:0]   new_max;
    logic [LEN_W-1:0]   cand_len;
    logic               sat_ovf;
    logic [LEN_W-1:0]   fin_len;
    logic               fin_ovf;
    logic [STATE_W-1:0] next_state;
    logic [CR_W-1:0]    next_cr;

    // Read the stored length fields out of the incoming state word.
    always_comb begin
        kept_max = state_i[MVL_LO +: LEN_W];
        kept_len = state_i[VL_LO +: LEN_W];
    end

    vl_src_select #(
        .LEN_W   (LEN_W),
        .FIELD_W (FIELD_W),
        .DATA_W  (DATA_W)
    ) i_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_valid_i (exec_i),
        .imm_i       (imm_i),
        .set_len_i   (set_len_i),
        .src_field_i (src_field_i),
        .dst_field_i (dst_field_i),
        .src_val_i   (src_val_i),
        .ctr_i       (ctr_i),
        .kept_len_i  (kept_len),
        .eff_imm_o   (eff_imm),
        .cand_o      (cand_len),
        .sat_ovf_o   (sat_ovf)
    );

    // Maximum length comes from the immediate only when asked.
    always_comb begin
        new_max = set_max_i ? eff_imm : kept_max;
    end

    vl_len_clamp #(
        .LEN_W (LEN_W)
    ) i_clamp (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_valid_i (exec_i),
        .cand_i      (cand_len),
        .max_i       (new_max),
        .in_ovf_i    (sat_ovf),
        .len_o       (fin_len),
        .ovf_o       (fin_ovf)
    );

    vl_state_merge #(
        .STATE_W (STATE_W),
        .LEN_W   (LEN_W)
    ) i_merge (
        .state_i   (state_i),
        .max_len_i (new_max),
        .len_i     (fin_len),
        .set_max_i (set_max_i),
        .vfirst_i  (vfirst_i),
        .state_o   (next_state)
    );

    // Condition field describes the length, not the destination register.
    always_comb begin
        next_cr        = '0;
        next_cr[CR_LT] = 1'b0;
        next_cr[CR_GT] = (fin_len != '0);
        next_cr[CR_EQ] = (fin_len == '0);
        next_cr[CR_SO] = fin_ovf;
    end

    // Register every result and its write-enable on the execute strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o    <= '0;
            state_we_o <= 1'b0;
            rt_we_o    <= 1'b0;
            rt_idx_o   <= '0;
            rt_data_o  <= '0;
            cr_we_o    <= 1'b0;
            cr_o       <= '0;
        end else begin
            state_we_o <= exec_i;
            rt_we_o    <= exec_i && (dst_field_i != '0);
            cr_we_o    <= exec_i && rec_i;
            if (exec_i) begin
                state_o   <= next_state;
                rt_idx_o  <= dst_field_i;
                rt_data_o <= {{(DATA_W-LEN_W){1'b0}}, fin_len};
                cr_o      <= next_cr;
            end
        end
    end

    // R8: a destination write carries the committed length, zero-extended.
    assert_rt_is_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rt_we_o |-> (rt_idx_o != '0 && state_we_o &&
                     rt_data_o == {{(DATA_W-LEN_W){1'b0}}, state_o[VL_LO +: LEN_W]}));

    // R10: the condition field reflects the committed length.
    assert_cr_form_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we_o |-> (!cr_o[CR_LT] && cr_o[CR_GT] != cr_o[CR_EQ] &&
                     cr_o[CR_EQ] == (state_o[VL_LO +: LEN_W] == '0)));

    // R11: no write-enable appears without a preceding strobe.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !state_we_o |-> (!rt_we_o && !cr_we_o));

    // R9: a maximum-length load leaves persistence cleared in the next cycle.
    assert_persist_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && set_max_i) |=> (state_we_o && !state_o[1]));

    // R2: the maximum length is carried over when not being loaded.
    assert_keep_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !set_max_i) |=> (state_o[MVL_LO +: LEN_W] == $past(state_i[MVL_LO +: LEN_W])));

endmodule

// File: tb/test_vl_set_unit.sv
// Bench: behavioural reference model of the set-length operation,
// compared against the unit's registered outputs every clock.
module test_vl_set_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exec_i;
    logic [6:0]  imm_i;
    logic        set_max_i, set_len_i, vfirst_i, rec_i;
    logic [4:0]  src_field_i, dst_field_i;
    logic [63:0] src_val_i, ctr_i;
    logic [63:0] state_i;
    logic [63:0] state_o;
    logic        state_we_o, rt_we_o, cr_we_o;
    logic [4:0]  rt_idx_o;
    logic [63:0] rt_data_o;
    logic [3:0]  cr_o;

    logic [63:0] model_state;
    int          n_tests = 0;
    int          n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign state_i = model_state;

    vl_set_unit i_vl_set_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .exec_i      (exec_i),
        .imm_i       (imm_i),
        .set_max_i   (set_max_i),
        .set_len_i   (set_len_i),
        .vfirst_i    (vfirst_i),
        .src_field_i (src_field_i),
        .dst_field_i (dst_field_i),
        .src_val_i   (src_val_i),
        .ctr_i       (ctr_i),
        .rec_i       (rec_i),
        .state_i     (state_i),
        .state_o     (state_o),
        .state_we_o  (state_we_o),
        .rt_we_o     (rt_we_o),
        .rt_idx_o    (rt_idx_o),
        .rt_data_o   (rt_data_o),
        .cr_we_o     (cr_we_o),
        .cr_o        (cr_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One operation: drive at a falling edge, compare at the next falling edge.
    task automatic run_op(input string tag, input bit sm, input bit sl, input bit vf,
                          input int imm, input int src, input int dst,
                          input longint unsigned val, input longint unsigned ctr,
                          input bit rec);
        int          mvl;
        int          vl;
        bit          ovf;
        logic [63:0] exp_state;
        ovf = 0;
        if (sm) mvl = (imm + 1) % 128;
        else    mvl = int'(model_state[63:57]);
        if (!sl) begin
            vl = int'(model_state[56:50]);
        end else if (src != 0) begin
            if (val > 64'd127) begin vl = 127; ovf = 1; end
            else vl = int'(val);
        end else if (dst == 0) begin
            vl = (imm + 1) % 128;
        end else begin
            if (ctr > 64'd127) begin vl = 127; ovf = 1; end
            else vl = int'(ctr);
        end
        if (vl > mvl) begin vl = mvl; ovf = 1; end
        exp_state        = model_state;
        exp_state[63:57] = 7'(mvl);
        exp_state[56:50] = 7'(vl);
        if (sm) begin
            exp_state[0] = vf;
            exp_state[1] = 1'b0;
        end
        exec_i = 1'b1; set_max_i = sm; set_len_i = sl; vfirst_i = vf;
        imm_i = 7'(imm); src_field_i = 5'(src); dst_field_i = 5'(dst);
        src_val_i = val; ctr_i = ctr; rec_i = rec;
        @(negedge clk);
        exec_i = 1'b0;
        check(tag, "state_we", {63'd0, state_we_o}, 64'd1);
        check(tag, "state", state_o, exp_state);
        check(tag, "rt_we", {63'd0, rt_we_o}, {63'd0, dst != 0});
        if (dst != 0) begin
            check(tag, "rt_idx", {59'd0, rt_idx_o}, 64'(dst));
            check(tag, "rt_data", rt_data_o, 64'(vl));
        end
        check(tag, "cr_we", {63'd0, cr_we_o}, {63'd0, rec});
        if (rec)
            check(tag, "cr", {60'd0, cr_o}, {60'd0, 1'b0, vl != 0, vl == 0, ovf});
        model_state = exp_state;
    endtask

    // Idle cycle: no write-enable may rise.
    task automatic idle_cycle(input string tag);
        @(negedge clk);
        check(tag, "idle we", {61'd0, state_we_o, rt_we_o, cr_we_o}, 64'd0);
    endtask

    function automatic logic [63:0] with_len(input logic [63:0] base, input int mvl, input int vl);
        logic [63:0] s;
        s        = base;
        s[63:57] = 7'(mvl);
        s[56:50] = 7'(vl);
        return s;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; exec_i = 1'b0; imm_i = '0; set_max_i = 0; set_len_i = 0;
        vfirst_i = 0; rec_i = 0; src_field_i = '0; dst_field_i = '0;
        src_val_i = '0; ctr_i = '0; model_state = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "reset outputs",
              {state_o[31:0] | state_o[63:32], 21'd0, state_we_o, rt_we_o, cr_we_o, cr_o, rt_idx_o},
              64'd0);
        check("R11", "reset rt_data", rt_data_o, 64'd0);
        rst_n = 1'b1;
        idle_cycle("R11");

        model_state = with_len(64'hA5C3_0F0F_F0F0_3C5B, 20, 5);
        run_op("R1", 1, 0, 1, 7, 0, 0, 0, 0, 1);      // MVL 8, VL kept 5
        run_op("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0);      // nothing changes
        run_op("R1", 1, 1, 0, 127, 0, 0, 0, 0, 1);    // MVL 0, VL 0, EQ
        run_op("R5", 1, 1, 1, 15, 0, 0, 0, 0, 1);     // MVL 16, VL 16
        run_op("R7", 0, 0, 0, 0, 0, 3, 0, 0, 1);      // read-back of VL into r3
        model_state = with_len(64'h0123_4567_89AB_CDEF, 100, 9);
        run_op("R4", 0, 1, 0, 0, 3, 0, 64'd50, 0, 1);
        run_op("R4", 0, 1, 0, 0, 3, 7, 64'd127, 0, 1);
        run_op("R4", 0, 1, 0, 0, 3, 7, 64'd128, 0, 1);
        run_op("R4", 0, 1, 0, 0, 1, 0, 64'h1_0000_0005, 0, 1);
        run_op("R6", 0, 1, 0, 0, 0, 4, 64'd77, 64'd20, 1);
        run_op("R6", 0, 1, 0, 0, 0, 4, 0, 64'h100_0000_0000, 1);
        run_op("R6", 0, 1, 0, 0, 0, 31, 0, 64'd0, 1);
        run_op("R7", 1, 1, 0, 15, 0, 0, 0, 0, 1);     // MVL 16, VL 16
        run_op("R7", 0, 1, 0, 63, 0, 0, 0, 0, 1);     // VL 64 clamps to 16
        run_op("R2", 0, 1, 0, 3, 0, 0, 0, 0, 0);      // MVL kept
        model_state = with_len(64'hFFFF_FFFF_FFFF_FFFF, 50, 40);
        run_op("R9", 0, 1, 0, 9, 0, 0, 0, 0, 0);      // mode bits stay 1
        run_op("R9", 1, 0, 0, 60, 0, 0, 0, 0, 0);     // vf 0, persist cleared
        model_state[1] = 1'b1;
        run_op("R9", 1, 0, 1, 60, 0, 0, 0, 0, 0);
        run_op("R8", 1, 1, 0, 60, 0, 12, 0, 64'd33, 0);
        run_op("R10", 0, 1, 0, 0, 0, 0, 0, 0, 0);     // no CR write when record clear
        idle_cycle("R11");

        for (int k = 0; k < 400; k++) begin
            longint unsigned v;
            longint unsigned c;
            model_state = {$urandom, $urandom};
            v = ($urandom % 3 == 0) ? {$urandom, $urandom} : 64'($urandom % 200);
            c = ($urandom % 3 == 0) ? {$urandom, $urandom} : 64'($urandom % 200);
            run_op("R11", bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2),
                   int'($urandom % 128),
                   ($urandom % 2 == 0) ? 0 : int'($urandom % 32),
                   ($urandom % 2 == 0) ? 0 : int'($urandom % 32),
                   v, c, bit'($urandom % 2));
            if (k % 7 == 0) idle_cycle("R11");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule